// File: doc/BRIEF.md
# Tileable Switching-Matrix Host Interface

This block is the processor-facing front end of a time-slot switching matrix that may be tiled with identical devices sharing one pair of chip selects. The host writes 5-bit opcodes or operand data with asynchronous write and read strobes. The block brings those strobes into the master clock domain and captures the bus and control pins. It decodes the opcode into an instruction number and hands it to the execution core as a one-cycle command pulse. The pad-level tristate sits outside the block: the bus arrives as a 5-bit input and leaves as an 8-bit output plus an output enable.

Each device compares its two address pins with its two hard-wired select pins. A device whose address differs does not simply ignore an opcode. Instructions 1 and 3 turn into a channel disconnect. Instruction 5 runs as written. Instructions 2, 4 and 6 are dropped. Reads return one of two status registers, and only a matching device drives the bus.

An active-low ready flag tells the host about two kinds of event. It latches low on an undefined opcode and stays low until a defined one is written. It also dips low for a fixed number of cycles when the core reports an active channel search hit or a completed zero-slot count.

Top module: `mhi_host_if`

## Requirements
- R1: Writing opcode 1 to 6 with `cmd_sel_i`=1 on a matching device gives a one-cycle `cmd_valid_o` carrying that number in `cmd_num_o` with `cmd_disc_o`=0, on the third clock edge after the write strobe rises.
- R2: A write with `cmd_sel_i`=0 gives a one-cycle `data_valid_o` with `data_o` equal to `bus_i`, on the same timing as R1 and whatever the match state, and no command pulse.
- R3: A write or read takes effect only when both `cs_a_ni` and `cs_b_ni` are low; the two selects behave identically.
- R4: The device matches when `adr1_i`==`sel1_i` and `adr2_i`==`sel2_i`; a difference in either pair gives a mismatch.
- R5: On a mismatch, opcodes 1 and 3 are issued with `cmd_disc_o`=1, opcode 5 is issued with `cmd_disc_o`=0, and opcodes 2, 4 and 6 produce no command pulse.
- R6: While reset is high, both selects are low, `rd_ni` is low and the device matches, `bus_oe_o` is 1 and `bus_o` shows `or1_i` when `cmd_sel_i`=0 and `or2_i` when it is 1; otherwise `bus_oe_o` is 0.
- R7: A selected read strobe rising gives a one-cycle `rd_evt_o` on the third clock edge after the rise, with `rd_reg_o` equal to the captured `cmd_sel_i` and `rd_match_o` equal to the captured match, also on a mismatch.
- R8: A selected opcode write of code 0 or 7 to 31 drives `rdy_no` low from the same edge as R1, and it stays low until a selected write of a code 1 to 6.
- R9: A high `act_hit_i` or `cnt_done_i` at a clock edge holds `rdy_no` low for exactly PULSE_LEN (default 2) cycles starting at that edge.
- R10: While `rst_ni` is low, `cmd_valid_o`, `data_valid_o`, `rd_evt_o` and `bus_oe_o` are 0 and `rdy_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 5 | Low bus bits written by the host |
| bus_o | output | 8 | Read data toward the pad |
| bus_oe_o | output | 1 | Pad output enable |
| cmd_sel_i | input | 1 | 1 = opcode / register 2, 0 = data / register 1 |
| cs_a_ni | input | 1 | Chip select, active low |
| cs_b_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| adr1_i | input | 1 | Address pin, pair 1 |
| sel1_i | input | 1 | Select pin, pair 1 |
| adr2_i | input | 1 | Address pin, pair 2 |
| sel2_i | input | 1 | Select pin, pair 2 |
| or1_i | input | 8 | Output register 1 contents |
| or2_i | input | 8 | Output register 2 contents |
| act_hit_i | input | 1 | Core found an active output channel |
| cnt_done_i | input | 1 | Core finished the zero-slot count |
| cmd_valid_o | output | 1 | Decoded command pulse |
| cmd_num_o | output | 3 | Instruction number |
| cmd_disc_o | output | 1 | Execute as channel disconnect |
| data_valid_o | output | 1 | Operand data pulse |
| data_o | output | 5 | Operand data |
| rd_evt_o | output | 1 | Read completed pulse |
| rd_reg_o | output | 1 | Register that was read |
| rd_match_o | output | 1 | Match state at the read |
| rdy_no | output | 1 | Ready flag, active low |

## Verification
Command, data and read-event pulses are due on the third clock edge after the strobe rises: two synchroniser stages, then the output register. A scoreboard queue pairs each written opcode or data word with the next pulse. Queued items that never appear, and pulses nobody queued, both count as failures, so a dropped instruction is checked by its absence. The read bus is combinational and is sampled while the read strobe is still low. The sticky ready flag is sampled after the same three edges. The pulsed ready flag is sampled one, two and three falling edges after the event, which covers its first cycle low, its last cycle low, and its return high.

// File: rtl/mhi_pkg.sv
package mhi_pkg;
  localparam int unsigned OP_W  = 5;
  localparam int unsigned NUM_W = 3;

  localparam logic [NUM_W-1:0] OP_MIN = 3'd1;
  localparam logic [NUM_W-1:0] OP_MAX = 3'd6;

  function automatic logic op_defined(input logic [OP_W-1:0] code);
    return (code >= OP_W'(OP_MIN)) && (code <= OP_W'(OP_MAX));
  endfunction

  // mismatch rewriting: 0 = drop, 1 = issue, disc = run as disconnect
  function automatic logic [1:0] remote_action(input logic [NUM_W-1:0] num);
    case (num)
      3'd1, 3'd3: return 2'b11;
      3'd5:       return 2'b01;
      default:    return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/mhi_strobe_sync.sv
module mhi_strobe_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strb_ni,
  input  logic [W-1:0] pins_i,
  output logic         rise_o,
  output logic [W-1:0] pins_o
);
  logic         s1_q, s2_q, s3_q;
  logic [W-1:0] p1_q, p2_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      p1_q   <= '0;
      p2_q   <= '0;
      hold_q <= '0;
    end else begin
      s1_q <= strb_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
      p1_q <= pins_i;
      p2_q <= p1_q;
      // keep the last pin sample seen while the strobe was low
      if (!s2_q) hold_q <= p2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign pins_o = hold_q;
endmodule

// File: rtl/mhi_decode.sv
module mhi_decode
  import mhi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_rise_i,
  input  logic             cs_ok_i,
  input  logic             match_i,
  input  logic             cmd_sel_i,
  input  logic [OP_W-1:0]  bus_i,
  output logic             cmd_valid_o,
  output logic [NUM_W-1:0] cmd_num_o,
  output logic             cmd_disc_o,
  output logic             data_valid_o,
  output logic [OP_W-1:0]  data_o,
  output logic             bad_op_o,
  output logic             good_op_o
);
  logic             op_wr, dat_wr, defined, issue, disc;
  logic [NUM_W-1:0] num;
  logic [1:0]       act;

  always_comb begin
    op_wr   = wr_rise_i & cs_ok_i & cmd_sel_i;
    dat_wr  = wr_rise_i & cs_ok_i & ~cmd_sel_i;
    defined = op_defined(bus_i);
    num     = bus_i[NUM_W-1:0];
    act     = remote_action(num);
    issue   = op_wr & defined & (match_i | act[0]);
    disc    = ~match_i & act[1];
  end

  assign bad_op_o  = op_wr & ~defined;
  assign good_op_o = op_wr & defined;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o  <= 1'b0;
      cmd_num_o    <= '0;
      cmd_disc_o   <= 1'b0;
      data_valid_o <= 1'b0;
      data_o       <= '0;
    end else begin
      cmd_valid_o  <= issue;
      data_valid_o <= dat_wr;
      if (issue) begin
        cmd_num_o  <= num;
        cmd_disc_o <= disc;
      end
      if (dat_wr) data_o <= bus_i;
    end
  end

  p_disc_only_13_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_disc_o |-> (cmd_num_o == 3'd1 || cmd_num_o == 3'd3));
  p_cmd_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_num_o >= OP_MIN && cmd_num_o <= OP_MAX && !data_valid_o));
  p_cmd_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: rtl/mhi_ready.sv
module mhi_ready #(
  parameter int unsigned PULSE_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bad_op_i,
  input  logic good_op_i,
  input  logic act_hit_i,
  input  logic cnt_done_i,
  output logic rdy_no
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic          sticky_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (bad_op_i)       sticky_q <= 1'b1;
      else if (good_op_i) sticky_q <= 1'b0;
      if (act_hit_i || cnt_done_i) cnt_q <= CW'(PULSE_LEN);
      else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdy_no = ~(sticky_q | (cnt_q != '0));

  p_event_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_hit_i || cnt_done_i) |=> !rdy_no);
  p_bad_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op_i |=> !rdy_no);
endmodule

// File: rtl/mhi_host_if.sv
module mhi_host_if
  import mhi_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  bus_i,
  output logic [7:0]       bus_o,
  output logic             bus_oe_o,
  input  logic             cmd_sel_i,
  input  logic             cs_a_ni,
  input  logic             cs_b_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic             adr1_i,
  input  logic             sel1_i,
  input  logic             adr2_i,
  input  logic             sel2_i,
  input  logic [7:0]       or1_i,
  input  logic [7:0]       or2_i,
  input  logic             act_hit_i,
  input  logic             cnt_done_i,
  output logic             cmd_valid_o,
  output logic [NUM_W-1:0] cmd_num_o,
  output logic             cmd_disc_o,
  output logic             data_valid_o,
  output logic [OP_W-1:0]  data_o,
  output logic             rd_evt_o,
  output logic             rd_reg_o,
  output logic             rd_match_o,
  output logic             rdy_no
);
  localparam int unsigned WR_W = OP_W + 3;
  localparam int unsigned RD_W = 3;

  logic cs_ok, match;
  assign cs_ok = ~cs_a_ni & ~cs_b_ni;
  assign match = (adr1_i == sel1_i) & (adr2_i == sel2_i);

  logic            wr_rise, rd_rise;
  logic [WR_W-1:0] wr_pins;
  logic [RD_W-1:0] rd_pins;

  mhi_strobe_sync #(.W(WR_W)) u_wr_sync (
    .clk_i, .rst_ni, .strb_ni(wr_ni),
    .pins_i({cs_ok, match, cmd_sel_i, bus_i}),
    .rise_o(wr_rise), .pins_o(wr_pins)
  );

  mhi_strobe_sync #(.W(RD_W)) u_rd_sync (
    .clk_i, .rst_ni, .strb_ni(rd_ni),
    .pins_i({cs_ok, match, cmd_sel_i}),
    .rise_o(rd_rise), .pins_o(rd_pins)
  );

  logic bad_op, good_op;

  mhi_decode u_dec (
    .clk_i, .rst_ni,
    .wr_rise_i(wr_rise),
    .cs_ok_i(wr_pins[WR_W-1]),
    .match_i(wr_pins[WR_W-2]),
    .cmd_sel_i(wr_pins[WR_W-3]),
    .bus_i(wr_pins[OP_W-1:0]),
    .cmd_valid_o, .cmd_num_o, .cmd_disc_o,
    .data_valid_o, .data_o,
    .bad_op_o(bad_op), .good_op_o(good_op)
  );

  mhi_ready #(.PULSE_LEN(PULSE_LEN)) u_rdy (
    .clk_i, .rst_ni,
    .bad_op_i(bad_op), .good_op_i(good_op),
    .act_hit_i, .cnt_done_i, .rdy_no
  );

  // read flow is tracked even when this device does not drive the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_evt_o   <= 1'b0;
      rd_reg_o   <= 1'b0;
      rd_match_o <= 1'b0;
    end else begin
      rd_evt_o <= rd_rise & rd_pins[2];
      if (rd_rise && rd_pins[2]) begin
        rd_match_o <= rd_pins[1];
        rd_reg_o   <= rd_pins[0];
      end
    end
  end

  assign bus_oe_o = rst_ni & cs_ok & ~rd_ni & match;
  assign bus_o    = cmd_sel_i ? or2_i : or1_i;

  p_rd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_o |=> !rd_evt_o);
  p_no_drive_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && rd_ni) |-> !bus_oe_o);
endmodule

// File: tb/mhi_host_if_tb_top.sv
module mhi_host_if_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [4:0] bus_i = '0;
  logic [7:0] bus_o;
  logic       bus_oe;
  logic       cmd_sel = 1'b0, cs_a_n = 1'b1, cs_b_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic       adr1 = 1'b0, sel1 = 1'b0, adr2 = 1'b0, sel2 = 1'b0;
  logic [7:0] or1 = 8'hC3, or2 = 8'h3C;
  logic       act_hit = 1'b0, cnt_done = 1'b0;
  logic       cmd_valid, cmd_disc, data_valid, rd_evt, rd_reg, rd_match, rdy_n;
  logic [2:0] cmd_num;
  logic [4:0] data;

  mhi_host_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe),
    .cmd_sel_i(cmd_sel), .cs_a_ni(cs_a_n), .cs_b_ni(cs_b_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .adr1_i(adr1), .sel1_i(sel1), .adr2_i(adr2), .sel2_i(sel2),
    .or1_i(or1), .or2_i(or2), .act_hit_i(act_hit), .cnt_done_i(cnt_done),
    .cmd_valid_o(cmd_valid), .cmd_num_o(cmd_num), .cmd_disc_o(cmd_disc),
    .data_valid_o(data_valid), .data_o(data),
    .rd_evt_o(rd_evt), .rd_reg_o(rd_reg), .rd_match_o(rd_match), .rdy_no(rdy_n)
  );

  int tests = 0, fails = 0;
  logic [3:0] cmd_q[$];   // {disc, num}
  logic [4:0] dat_q[$];
  logic done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (cmd_q.size() == 0) check("R5 unexpected command", {cmd_disc, cmd_num}, 32'hF);
      else check("R1/R5 command", {28'd0, cmd_disc, cmd_num}, {28'd0, cmd_q.pop_front()});
    end
    if (rst_n && data_valid) begin
      if (dat_q.size() == 0) check("R2 unexpected data", data, 32'h1F);
      else check("R2 data", data, dat_q.pop_front());
    end
  end

  task automatic write(input logic sel, input logic [4:0] v);
    @(negedge clk);
    bus_i = v; cmd_sel = sel; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_cmd(input logic disc, input logic [2:0] num);
    cmd_q.push_back({disc, num});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 cmd_valid in reset", cmd_valid, 0);
    check("R10 rdy_no in reset", rdy_n, 1);
    rd_n = 1'b0; cs_a_n = 1'b0; cs_b_n = 1'b0;
    #1 check("R10 bus_oe in reset", bus_oe, 0);
    rd_n = 1'b1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: matching opcodes
    for (int k = 1; k <= 6; k++) begin
      expect_cmd(1'b0, 3'(k));
      write(1'b1, 5'(k));
    end
    check("R1 ready high after defined opcodes", rdy_n, 1);

    // R2: data write
    dat_q.push_back(5'h15);
    write(1'b0, 5'h15);

    // R4/R5: mismatch on pair 1
    adr1 = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      if (k == 1 || k == 3) expect_cmd(1'b1, 3'(k));
      else if (k == 5) expect_cmd(1'b0, 3'(k));
      write(1'b1, 5'(k));
    end
    dat_q.push_back(5'h0A);  // R2 data passes on mismatch
    write(1'b0, 5'h0A);
    // R4: mismatch on pair 2 only
    adr1 = 1'b0; sel2 = 1'b1;
    expect_cmd(1'b1, 3'd3);
    write(1'b1, 5'd3);
    write(1'b1, 5'd4);
    // R4: pins swapped within a pair still match
    adr2 = 1'b1; sel2 = 1'b1; adr1 = 1'b1; sel1 = 1'b1;
    expect_cmd(1'b0, 3'd4);
    write(1'b1, 5'd4);
    check("R5 queue drained", cmd_q.size(), 0);

    // R8: sticky invalid opcode
    write(1'b1, 5'd0);
    check("R8 ready low after code 0", rdy_n, 0);
    repeat (10) @(negedge clk);
    check("R8 ready still low", rdy_n, 0);
    dat_q.push_back(5'h01);
    write(1'b0, 5'h01);
    check("R8 data write keeps low", rdy_n, 0);
    expect_cmd(1'b0, 3'd2);
    write(1'b1, 5'd2);
    check("R8 ready released", rdy_n, 1);
    write(1'b1, 5'd31);
    check("R8 ready low after code 31", rdy_n, 0);
    expect_cmd(1'b0, 3'd6);
    write(1'b1, 5'd6);
    check("R8 ready released again", rdy_n, 1);

    // R3: either select high blocks access
    cs_a_n = 1'b1;
    write(1'b1, 5'd7);
    check("R3 cs_a high ignores write", rdy_n, 1);
    cs_a_n = 1'b0; cs_b_n = 1'b1;
    write(1'b1, 5'd2);
    write(1'b1, 5'd9);
    check("R3 cs_b high ignores write", rdy_n, 1);
    cs_b_n = 1'b0;
    check("R3 no command from deselected writes", cmd_q.size(), 0);

    // R9: pulsed ready
    @(negedge clk); act_hit = 1'b1;
    @(negedge clk); act_hit = 1'b0;
    check("R9 act first low", rdy_n, 0);
    @(negedge clk); check("R9 act second low", rdy_n, 0);
    @(negedge clk); check("R9 act back high", rdy_n, 1);
    @(negedge clk); cnt_done = 1'b1;
    @(negedge clk); cnt_done = 1'b0;
    check("R9 count first low", rdy_n, 0);
    @(negedge clk); check("R9 count second low", rdy_n, 0);
    @(negedge clk); check("R9 count back high", rdy_n, 1);

    // R6/R7: reads
    @(negedge clk); cmd_sel = 1'b0; rd_n = 1'b0;
    #1 check("R6 oe on reg1", bus_oe, 1);
    check("R6 reg1 value", bus_o, 8'hC3);
    repeat (2) @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 evt reg1", {rd_evt, rd_reg, rd_match}, 3'b101);
    @(negedge clk); check("R7 evt one cycle", rd_evt, 0);
    cmd_sel = 1'b1; rd_n = 1'b0;
    #1 check("R6 reg2 value", {bus_oe, bus_o}, {1'b1, 8'h3C});
    repeat (2) @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 evt reg2", {rd_evt, rd_reg, rd_match}, 3'b111);
    repeat (2) @(negedge clk);
    sel1 = 1'b0; cmd_sel = 1'b0; rd_n = 1'b0;
    #1 check("R6 mismatch no drive", bus_oe, 0);
    repeat (2) @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 evt on mismatch", {rd_evt, rd_reg, rd_match}, 3'b100);
    repeat (2) @(negedge clk);
    sel1 = 1'b1; cs_a_n = 1'b1; rd_n = 1'b0;
    #1 check("R3 deselected read no drive", bus_oe, 0);
    repeat (2) @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 deselected read no event", rd_evt, 0);
    cs_a_n = 1'b0;

    repeat (4) @(negedge clk);
    check("R1 all commands seen", cmd_q.size(), 0);
    check("R2 all data seen", dat_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule